// File: doc/BRIEF.md
# Tag-Matching Reservation Station Array

This block is the scheduling front of one functional-unit class, for example the integer adder. A single issue port delivers operations in program order. Each operation carries an opcode, a destination register and two source registers. The block owns a small register file and a rename table. The rename table records, for each register, which station will produce its next value. At issue an operation takes the lowest-numbered free station. Each source operand is filled in one of two ways: with the value when that value is already known, or with the tag of the station that will produce it. The destination register is then renamed to the new station's tag.

Stations whose operands are still missing watch a broadcast result bus. The bus carries a data word and a 4-bit source tag. Any waiting operand, and any register whose rename entry holds the same tag, takes the data. When both operands are present, the station can be dispatched into a pipelined execution unit with a fixed latency. At most one station is dispatched per cycle, and the lowest index goes first. The unit's result leaves the block as a tagged result, and the surrounding logic places it on the broadcast bus. When a station's own tag appears on the bus, that station is freed. Tag zero means "value present", so no separate ready flag exists.

Top module: `tag_match_rs`

## Requirements
- R1: After reset every station is free, so `issueReady` is 1 and `dispValid` and `resValid` are 0. Register k holds the value k and has no pending producer.
- R2: An accepted issue (`issueValid` and `issueReady` both 1) takes the lowest-numbered free station. Station i carries tag i+1. When every station is busy, `issueReady` is 0 and an issue offered in that cycle has no effect on any station or register.
- R3: At issue, a source whose register has no pending producer is copied from the register file. A source whose producer's tag is on the bus in that same cycle takes the bus data directly. Any other source keeps the producer's tag and waits.
- R4: A station is dispatched only when both of its tags are zero. Among ready stations the lowest index is dispatched first. At most one station is dispatched per cycle, and a station is never dispatched twice for one issue.
- R5: A station dispatched in cycle c produces `resValid` with its own tag in cycle c+EXEC_LAT. The result is A+B for opcode 0, A−B for opcode 1, A AND B for opcode 2 and A XOR B for opcode 3, all modulo 2^DATA_W.
- R6: A waiting operand whose tag equals `cdbTag` while `cdbValid` is 1 takes `cdbData` and clears its tag.
- R7: A busy station whose tag is broadcast becomes free, and it can accept an issue from the next cycle on.
- R8: A register whose rename entry matches the broadcast tag takes the data and clears the entry. An issue naming that register as destination in the same cycle keeps the new tag, so a later reader sees the younger result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | Issue request |
| issueOp | input | 2 | Opcode: 0 add, 1 sub, 2 and, 3 xor |
| issueDst | input | REG_W | Destination register |
| issueSrcA | input | REG_W | First source register |
| issueSrcB | input | REG_W | Second source register |
| issueReady | output | 1 | At least one station is free |
| cdbValid | input | 1 | Broadcast bus carries a result |
| cdbTag | input | 4 | Producing station tag on the bus |
| cdbData | input | DATA_W | Result data on the bus |
| dispValid | output | 1 | A station enters the execution unit this cycle |
| dispTag | output | 4 | Tag of the dispatched station |
| resValid | output | 1 | Execution unit result valid |
| resTag | output | 4 | Tag of the station that produced the result |
| resData | output | DATA_W | Execution unit result |

## Verification
Four operations with no dependences, one per opcode, check the arithmetic, the station allocation and the values held in the register file after reset. A serial chain of writes to one register fills every station, and shows both the wake-up through the bus and the refusal of an issue while full. The refused operation's destination is read back afterwards to confirm it was left untouched. An issue placed exactly in its producer's broadcast cycle, with the same destination as that producer, separates direct capture and rename-table priority from the ordinary wait path. Three consumers woken by one broadcast expose the lowest-index-first dispatch order.

// File: rtl/rs_pkg.sv
package rs_pkg;

  // Tag width is fixed by the broadcast bus format; tag 0 means "value present".
  localparam int TAG_W = 4;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_AND = 2'd2,
    OP_XOR = 2'd3
  } alu_op_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic             issueEn;
    logic [TAG_W-1:0] issueTag;
    logic             dispEn;
    logic [TAG_W-1:0] dispTag;
  } rs_strobe_t;

endpackage

// File: rtl/rs_ctrl.sv
module rs_ctrl
  import rs_pkg::*;
#(
  parameter int NUM_RS = 4
) (
  input  logic              issueValid,
  input  logic [NUM_RS-1:0] busyVec,
  input  logic [NUM_RS-1:0] readyVec,
  output logic              issueReady,
  output rs_strobe_t        strobe
);

  // Priority pick: walking from the top index down lets the lowest index win.
  always_comb begin
    strobe = '0;
    for (int i = NUM_RS - 1; i >= 0; i--) begin
      if (!busyVec[i])  strobe.issueTag = TAG_W'(i + 1);
      if (readyVec[i])  strobe.dispTag  = TAG_W'(i + 1);
    end
    issueReady     = ~(&busyVec);
    strobe.issueEn = issueValid && issueReady;
    strobe.dispEn  = |readyVec;
  end

endmodule

// File: rtl/rs_data.sv
module rs_data
  import rs_pkg::*;
#(
  parameter int NUM_RS    = 4,
  parameter int NUM_REGS  = 8,
  parameter int DATA_W    = 64,
  parameter int EXEC_LAT  = 3,
  localparam int REG_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  rs_strobe_t        strobe,
  input  logic [1:0]        issueOp,
  input  logic [REG_W-1:0]  issueDst,
  input  logic [REG_W-1:0]  issueSrcA,
  input  logic [REG_W-1:0]  issueSrcB,
  input  logic              cdbValid,
  input  logic [TAG_W-1:0]  cdbTag,
  input  logic [DATA_W-1:0] cdbData,
  output logic [NUM_RS-1:0] busyVec,
  output logic [NUM_RS-1:0] readyVec,
  output logic              resValid,
  output logic [TAG_W-1:0]  resTag,
  output logic [DATA_W-1:0] resData
);

  // Station storage
  logic              stBusy    [NUM_RS];
  logic              stStarted [NUM_RS];
  alu_op_e           stOp      [NUM_RS];
  logic [DATA_W-1:0] stValA    [NUM_RS];
  logic [DATA_W-1:0] stValB    [NUM_RS];
  logic [TAG_W-1:0]  stTagA    [NUM_RS];
  logic [TAG_W-1:0]  stTagB    [NUM_RS];

  // Register file and rename table
  logic [DATA_W-1:0] regVal [NUM_REGS];
  logic [TAG_W-1:0]  regTag [NUM_REGS];

  // Issue-time operand lookup
  logic [TAG_W-1:0]  lookTagA, lookTagB;
  logic [DATA_W-1:0] inValA, inValB;
  logic [TAG_W-1:0]  inTagA, inTagB;

  always_comb begin
    lookTagA = regTag[issueSrcA];
    lookTagB = regTag[issueSrcB];
    inValA   = '0;
    inTagA   = '0;
    if (lookTagA == '0)                       inValA = regVal[issueSrcA];
    else if (cdbValid && cdbTag == lookTagA)  inValA = cdbData;
    else                                      inTagA = lookTagA;
    inValB   = '0;
    inTagB   = '0;
    if (lookTagB == '0)                       inValB = regVal[issueSrcB];
    else if (cdbValid && cdbTag == lookTagB)  inValB = cdbData;
    else                                      inTagB = lookTagB;
  end

  // Station update: load on issue, otherwise snoop, start and free
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_RS; i++) begin
        stBusy[i]    <= 1'b0;
        stStarted[i] <= 1'b0;
        stOp[i]      <= OP_ADD;
        stValA[i]    <= '0;
        stValB[i]    <= '0;
        stTagA[i]    <= '0;
        stTagB[i]    <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_RS; i++) begin
        if (strobe.issueEn && strobe.issueTag == TAG_W'(i + 1)) begin
          stBusy[i]    <= 1'b1;
          stStarted[i] <= 1'b0;
          stOp[i]      <= alu_op_e'(issueOp);
          stValA[i]    <= inValA;
          stValB[i]    <= inValB;
          stTagA[i]    <= inTagA;
          stTagB[i]    <= inTagB;
        end else begin
          if (cdbValid && cdbTag == TAG_W'(i + 1)) begin
            stBusy[i]    <= 1'b0;
            stStarted[i] <= 1'b0;
          end else if (strobe.dispEn && strobe.dispTag == TAG_W'(i + 1)) begin
            stStarted[i] <= 1'b1;
          end
          if (stTagA[i] != '0 && cdbValid && cdbTag == stTagA[i]) begin
            stValA[i] <= cdbData;
            stTagA[i] <= '0;
          end
          if (stTagB[i] != '0 && cdbValid && cdbTag == stTagB[i]) begin
            stValB[i] <= cdbData;
            stTagB[i] <= '0;
          end
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_RS; i++) begin
      busyVec[i]  = stBusy[i];
      readyVec[i] = stBusy[i] && !stStarted[i] && stTagA[i] == '0 && stTagB[i] == '0;
    end
  end

  // Register file and rename table: broadcast writes, then issue renames
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < NUM_REGS; r++) begin
        regVal[r] <= DATA_W'(r);
        regTag[r] <= '0;
      end
    end else begin
      for (int r = 0; r < NUM_REGS; r++) begin
        if (cdbValid && regTag[r] != '0 && regTag[r] == cdbTag) begin
          regVal[r] <= cdbData;
          regTag[r] <= '0;
        end
        if (strobe.issueEn && issueDst == REG_W'(r))
          regTag[r] <= strobe.issueTag;
      end
    end
  end

  // Dispatch operand select
  alu_op_e           exOp;
  logic [DATA_W-1:0] exA, exB, exRes;

  always_comb begin
    exOp = OP_ADD;
    exA  = '0;
    exB  = '0;
    for (int i = 0; i < NUM_RS; i++) begin
      if (strobe.dispTag == TAG_W'(i + 1)) begin
        exOp = stOp[i];
        exA  = stValA[i];
        exB  = stValB[i];
      end
    end
    unique case (exOp)
      OP_ADD:  exRes = exA + exB;
      OP_SUB:  exRes = exA - exB;
      OP_AND:  exRes = exA & exB;
      default: exRes = exA ^ exB;
    endcase
  end

  // Fixed-latency execution pipeline
  logic              pipeVal  [EXEC_LAT];
  logic [TAG_W-1:0]  pipeTag  [EXEC_LAT];
  logic [DATA_W-1:0] pipeData [EXEC_LAT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < EXEC_LAT; s++) begin
        pipeVal[s]  <= 1'b0;
        pipeTag[s]  <= '0;
        pipeData[s] <= '0;
      end
    end else begin
      pipeVal[0]  <= strobe.dispEn;
      pipeTag[0]  <= strobe.dispTag;
      pipeData[0] <= exRes;
      for (int s = 1; s < EXEC_LAT; s++) begin
        pipeVal[s]  <= pipeVal[s-1];
        pipeTag[s]  <= pipeTag[s-1];
        pipeData[s] <= pipeData[s-1];
      end
    end
  end

  assign resValid = pipeVal[EXEC_LAT-1];
  assign resTag   = pipeTag[EXEC_LAT-1];
  assign resData  = pipeData[EXEC_LAT-1];

endmodule

// File: rtl/tag_match_rs.sv
module tag_match_rs
  import rs_pkg::*;
#(
  parameter int NUM_RS   = 4,
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 64,
  parameter int EXEC_LAT = 3,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  input  logic [1:0]        issueOp,
  input  logic [REG_W-1:0]  issueDst,
  input  logic [REG_W-1:0]  issueSrcA,
  input  logic [REG_W-1:0]  issueSrcB,
  output logic              issueReady,
  input  logic              cdbValid,
  input  logic [TAG_W-1:0]  cdbTag,
  input  logic [DATA_W-1:0] cdbData,
  output logic              dispValid,
  output logic [TAG_W-1:0]  dispTag,
  output logic              resValid,
  output logic [TAG_W-1:0]  resTag,
  output logic [DATA_W-1:0] resData
);

  logic [NUM_RS-1:0] busyVec;
  logic [NUM_RS-1:0] readyVec;
  rs_strobe_t        strobe;

  rs_ctrl #(.NUM_RS(NUM_RS)) i_ctrl (
    .issueValid (issueValid),
    .busyVec    (busyVec),
    .readyVec   (readyVec),
    .issueReady (issueReady),
    .strobe     (strobe)
  );

  rs_data #(
    .NUM_RS   (NUM_RS),
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W),
    .EXEC_LAT (EXEC_LAT)
  ) i_data (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .issueOp   (issueOp),
    .issueDst  (issueDst),
    .issueSrcA (issueSrcA),
    .issueSrcB (issueSrcB),
    .cdbValid  (cdbValid),
    .cdbTag    (cdbTag),
    .cdbData   (cdbData),
    .busyVec   (busyVec),
    .readyVec  (readyVec),
    .resValid  (resValid),
    .resTag    (resTag),
    .resData   (resData)
  );

  assign dispValid = strobe.dispEn;
  assign dispTag   = strobe.dispTag;

endmodule

// File: rtl/rs_checker.sv
module rs_checker #(
  parameter int NUM_RS = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              issueValid,
  input logic              issueReady,
  input logic [NUM_RS-1:0] busyVec,
  input logic              dispValid,
  input logic [3:0]        dispTag,
  input logic              cdbValid,
  input logic [3:0]        cdbTag,
  input logic              resValid,
  input logic [3:0]        resTag
);

  assert_full_blocks_issue_R2: assert property (@(posedge clk) disable iff (!rstN)
    !issueReady |-> (&busyVec));

  assert_issue_takes_station_R2: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueReady && !cdbValid) |=>
      ($countones(busyVec) == $past($countones(busyVec)) + 1));

  assert_no_double_dispatch_R4: assert property (@(posedge clk) disable iff (!rstN)
    dispValid |=> !(dispValid && dispTag == $past(dispTag)));

  for (genvar i = 0; i < NUM_RS; i++) begin : g_st
    assert_free_on_bcast_R7: assert property (@(posedge clk) disable iff (!rstN)
      (cdbValid && cdbTag == 4'(i + 1) && busyVec[i]) |=> !busyVec[i]);

    assert_result_from_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
      (resValid && resTag == 4'(i + 1)) |-> busyVec[i]);
  end

endmodule

bind tag_match_rs rs_checker #(.NUM_RS(NUM_RS)) i_rsChk (
  .clk        (clk),
  .rstN       (rstN),
  .issueValid (issueValid),
  .issueReady (issueReady),
  .busyVec    (busyVec),
  .dispValid  (dispValid),
  .dispTag    (dispTag),
  .cdbValid   (cdbValid),
  .cdbTag     (cdbTag),
  .resValid   (resValid),
  .resTag     (resTag)
);

// File: tb/test_tag_match_rs.sv
`timescale 1ns/1ps
module test_tag_match_rs;

  localparam int NRS  = 4;
  localparam int NREG = 8;
  localparam int DW   = 64;
  localparam int LAT  = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          issueValid = 1'b0;
  logic [1:0]    issueOp = '0;
  logic [2:0]    issueDst = '0, issueSrcA = '0, issueSrcB = '0;
  logic          issueReady;
  logic          cdbValid;
  logic [3:0]    cdbTag;
  logic [DW-1:0] cdbData;
  logic          dispValid;
  logic [3:0]    dispTag;
  logic          resValid;
  logic [3:0]    resTag;
  logic [DW-1:0] resData;

  always #5 clk = ~clk;

  // The block's result is the only producer on the broadcast bus.
  assign cdbValid = resValid;
  assign cdbTag   = resTag;
  assign cdbData  = resData;

  tag_match_rs #(.NUM_RS(NRS), .NUM_REGS(NREG), .DATA_W(DW), .EXEC_LAT(LAT)) i_tag_match_rs (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueOp(issueOp),
    .issueDst(issueDst), .issueSrcA(issueSrcA), .issueSrcB(issueSrcB),
    .issueReady(issueReady), .cdbValid(cdbValid), .cdbTag(cdbTag), .cdbData(cdbData),
    .dispValid(dispValid), .dispTag(dispTag), .resValid(resValid), .resTag(resTag),
    .resData(resData)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // Reference model
  logic [DW-1:0] archReg [NREG];
  logic [DW-1:0] expVal [16];
  bit            expOk  [16];
  bit [NRS-1:0]  busyM = '0;
  bit [NRS-1:0]  freeNext = '0;
  int            dispLog [64];
  int            dispCyc [64];
  int            dispCnt = 0;
  int            cyc = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] aluRef(input logic [1:0] op, input logic [DW-1:0] a,
                                           input logic [DW-1:0] b);
    case (op)
      2'd0:    return a + b;
      2'd1:    return a - b;
      2'd2:    return a & b;
      default: return a ^ b;
    endcase
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: frees model stations one cycle after their broadcast, checks results.
  always @(negedge clk) begin
    busyM    = busyM & ~freeNext;
    freeNext = '0;
    if (rstN && dispValid && dispCnt < 64) begin
      dispLog[dispCnt] = int'(dispTag);
      dispCyc[dispCnt] = cyc;
      dispCnt++;
    end
    if (rstN && resValid) begin
      check(expOk[resTag], "R5", "result for unexpected tag", longint'(resTag), 0);
      check(resData == expVal[resTag], "R5", "result data", longint'(resData),
            longint'(expVal[resTag]));
      expOk[resTag] = 0;
      if (resTag >= 1 && resTag <= NRS) freeNext[resTag-1] = 1'b1;
    end
  end

  // Driver: pushes the expected result of each accepted issue.
  task automatic issue(input logic [1:0] op, input int dst, input int a, input int b);
    bit full;
    int slot;
    @(negedge clk); #1;
    full = &busyM;
    check(issueReady == !full, "R2", "issueReady", longint'(issueReady), longint'(!full));
    issueValid = 1'b1;
    issueOp    = op;
    issueDst   = 3'(dst);
    issueSrcA  = 3'(a);
    issueSrcB  = 3'(b);
    if (!full) begin
      slot = 0;
      for (int i = NRS - 1; i >= 0; i--) if (!busyM[i]) slot = i;
      busyM[slot]        = 1'b1;
      expVal[slot + 1]   = aluRef(op, archReg[a], archReg[b]);
      expOk[slot + 1]    = 1;
      archReg[dst]       = expVal[slot + 1];
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); #1;
      issueValid = 1'b0;
    end
  endtask

  task automatic drain(input string req);
    int guard = 0;
    bit left = 0;
    idle(1);
    while ((busyM != '0 || freeNext != '0) && guard < 200) begin
      @(negedge clk); #1;
      guard++;
    end
    for (int t = 1; t <= NRS; t++) if (expOk[t]) left = 1;
    check(!left && busyM == '0, req, "all issued results returned", longint'(busyM), 0);
  endtask

  initial begin
    for (int r = 0; r < NREG; r++) archReg[r] = DW'(r);
    for (int t = 0; t < 16; t++) begin expOk[t] = 0; expVal[t] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    // R1: reset state
    check(issueReady == 1'b1, "R1", "issueReady after reset", longint'(issueReady), 1);
    check(dispValid == 1'b0, "R1", "dispValid after reset", longint'(dispValid), 0);
    check(resValid == 1'b0, "R1", "resValid after reset", longint'(resValid), 0);

    // R1/R5: independent ops on reset register values, one of each opcode
    issue(2'd0, 0, 1, 2);
    issue(2'd1, 4, 5, 7);
    issue(2'd2, 5, 6, 3);
    issue(2'd3, 6, 6, 2);
    drain("R5");

    // R2/R6/R8: dependent chain on r1 fills all stations; extra issue refused
    issue(2'd0, 1, 2, 3);
    issue(2'd0, 1, 1, 2);
    issue(2'd1, 1, 1, 3);
    issue(2'd3, 1, 1, 2);
    issue(2'd0, 0, 5, 6);   // offered while full: must be ignored (R2)
    check(issueReady == 1'b0, "R2", "full blocks issue", longint'(issueReady), 0);
    drain("R6");
    issue(2'd0, 2, 1, 0);   // reads chain result r1 and untouched r0 (R2, R8)
    drain("R8");

    // R3/R8: issue in producer's broadcast cycle, same destination
    issue(2'd0, 3, 4, 5);   // station 0, dispatch next cycle
    idle(1);
    check(dispValid && dispTag == 4'd1, "R4", "dispatch one cycle after issue",
          longint'(dispTag), 1);
    idle(2);
    issue(2'd0, 3, 3, 3);   // r3 pending on tag 1, which is on the bus now
    check(resValid && resTag == 4'd1, "R5", "result latency 1+EXEC_LAT",
          longint'(resTag), 1);
    drain("R3");
    issue(2'd3, 7, 3, 0);   // must see the younger r3 (R8)
    drain("R8");

    // R4: three consumers woken by one broadcast dispatch lowest index first
    dispCnt = 0;
    issue(2'd0, 1, 2, 3);
    issue(2'd0, 4, 1, 0);
    issue(2'd1, 5, 1, 2);
    issue(2'd3, 6, 1, 3);
    drain("R4");
    check(dispCnt == 4, "R4", "dispatch count", dispCnt, 4);
    for (int k = 1; k < 4; k++) begin
      check(dispLog[k] == k + 1, "R4", "dispatch order tag", dispLog[k], k + 1);
      if (k > 1)
        check(dispCyc[k] == dispCyc[k-1] + 1, "R4", "one dispatch per cycle",
              dispCyc[k] - dispCyc[k-1], 1);
    end

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule